// File: doc/BRIEF.md
# Staged Bit-Permutation Unit

This block rearranges the bits of a 64-bit word through one shared ladder of log2(W) butterfly-style stages. Four permutation families are built on that ladder. Generalized reverse swaps groups of bits. Generalized OR-combine merges each bit with its swapped partner. Perfect shuffle and unshuffle interleave and de-interleave bit groups. A fifth mode replaces the plain swap of every active stage with a pair of 2-input lookup functions taken from an 8-bit immediate. Given an all-zero operand, that mode writes out regular constant patterns.

Each stage is switched as a whole by one bit of the control amount. No switch inside a stage has its own control. A narrow input makes the unit act on each 32-bit half on its own. It does this by clearing the highest control bit that the chosen family uses. The permuted word is registered, so it appears one clock after the inputs are applied.

Top module: `bitperm64`

## Requirements
- R1: While rst_n is low, result is 0. After reset, result shows the function of the inputs sampled at the previous rising clock edge: one cycle of latency.
- R2: op_sel=0 (reverse). For each k from 0 to 5 with ctl[k] set, applied in rising k, every 2^k-bit group trades places with its neighbouring group. ctl=63 reverses the whole word.
- R3: op_sel=1 (OR-combine). The stages are the same as in R2, but an active stage ORs the swapped word into the current word.
- R4: op_sel=2 (shuffle). Stage N keeps the bits outside maskL|maskR and ORs in ((x<<N)&maskL) and ((x>>N)&maskR). maskL holds the bits whose index mod 4N lies in [2N,3N), and maskR those in [N,2N). Stages run for N=16,8,4,2,1, gated by ctl[4],ctl[3],ctl[2],ctl[1],ctl[0]. ctl[5] is ignored.
- R5: op_sel=3 (unshuffle). It uses the same stages as R4 in the order N=1,2,4,8,16, so it undoes a shuffle with the same ctl. ctl[5] is ignored.
- R6: op_sel=4 (lookup reverse). In active stage k, with C=2^k, output bit j is nib[{x[j^C], x[j]}]. nib is imm[3:0] when bit k of j is 0, and imm[7:4] when it is 1. imm=8'hCC gives the same result as R2.
- R7: In lookup mode with operand 0, imm=8'hF0 gives 0xAAAA_AAAA_AAAA_AAAA for ctl=1 and 0xCCCC_CCCC_CCCC_CCCC for ctl=3.
- R8: When narrow=1, ctl[5] is treated as 0 for op_sel 0, 1 and 4, and ctl[4] as 0 for op_sel 2 and 3.
- R9: op_sel values 5, 6 and 7 pass the operand through unchanged.
- R10: Reverse, shuffle and unshuffle keep the number of set bits. OR-combine never clears a set bit. ctl=0 gives the identity for op_sel 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_sel | input | 3 | Operation: 0 reverse, 1 OR-combine, 2 shuffle, 3 unshuffle, 4 lookup reverse, 5-7 pass |
| narrow | input | 1 | Masks the top control bit of the chosen family |
| ctl | input | 6 | Control amount, one bit per stage |
| imm | input | 8 | Two 4-entry lookup tables for op_sel 4 |
| operand | input | 64 | Word to permute |
| result | output | 64 | Registered permuted word |

## Verification
The assertions check the following on every cycle: the reset value; the set-bit count kept by reverse, shuffle and unshuffle; the OR-combine never dropping a set bit; identity at ctl=0; and pass-through for the spare codes. Only the bench's scenarios can show that each stage uses the right masks, sizes and order. The bench compares all control values for every operation against a software model of the mask equations, and checks the lookup-table orientation, the constant patterns, shuffle followed by unshuffle, and the narrow masking.

// File: rtl/bitperm64.sv
module bitperm64 #(
  parameter int W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            op_sel,
  input  logic                  narrow,
  input  logic [$clog2(W)-1:0]  ctl,
  input  logic [7:0]            imm,
  input  logic [W-1:0]          operand,
  output logic [W-1:0]          result
);
  localparam int ST  = $clog2(W);
  localparam int SST = ST - 1;

  function automatic logic [W-1:0] shuf_mask(input int n, input bit left);
    logic [W-1:0] m;
    for (int j = 0; j < W; j++) begin
      int r;
      r = j % (4 * n);
      m[j] = left ? (r >= 2 * n && r < 3 * n) : (r >= n && r < 2 * n);
    end
    return m;
  endfunction

  function automatic logic [W-1:0] shuf_stage(input logic [W-1:0] x, input int n);
    logic [W-1:0] ml, mr;
    ml = shuf_mask(n, 1'b1);
    mr = shuf_mask(n, 1'b0);
    return (x & ~(ml | mr)) | ((x << n) & ml) | ((x >> n) & mr);
  endfunction

  logic [ST-1:0]  rctl;
  logic [SST-1:0] sctl;
  assign rctl = narrow ? (ctl & ~(ST'(1) << (ST - 1))) : ctl;
  assign sctl = narrow ? (ctl[SST-1:0] & ~(SST'(1) << (SST - 1))) : ctl[SST-1:0];

  logic [W-1:0] rv [0:ST];
  logic [W-1:0] sf [0:SST];
  logic [W-1:0] uf [0:SST];
  assign rv[0] = operand;
  assign sf[0] = operand;
  assign uf[0] = operand;

  for (genvar k = 0; k < ST; k++) begin : g_rev
    localparam int C = 1 << k;
    logic [W-1:0] so;
    always_comb begin
      logic [W-1:0] sw, lv;
      logic [3:0] nib;
      for (int j = 0; j < W; j++) begin
        sw[j] = rv[k][j ^ C];
        nib = ((j & C) != 0) ? imm[7:4] : imm[3:0];
        lv[j] = nib[{rv[k][j ^ C], rv[k][j]}];
      end
      if (!rctl[k])         so = rv[k];
      else if (op_sel == 3'd1) so = rv[k] | sw;
      else if (op_sel == 3'd4) so = lv;
      else                  so = sw;
    end
    assign rv[k+1] = so;
  end

  for (genvar i = 0; i < SST; i++) begin : g_shf
    localparam int NS = (W / 4) >> i;
    localparam int NU = 1 << i;
    assign sf[i+1] = sctl[SST-1-i] ? shuf_stage(sf[i], NS) : sf[i];
    assign uf[i+1] = sctl[i]       ? shuf_stage(uf[i], NU) : uf[i];
  end

  logic [W-1:0] nxt;
  always_comb begin
    case (op_sel)
      3'd0, 3'd1, 3'd4: nxt = rv[ST];
      3'd2:             nxt = sf[SST];
      3'd3:             nxt = uf[SST];
      default:          nxt = operand;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) result <= '0;
    else        result <= nxt;
endmodule

// File: rtl/bitperm64_chk.sv
module bitperm64_chk #(
  parameter int W = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           op_sel,
  input logic                 narrow,
  input logic [$clog2(W)-1:0] ctl,
  input logic [7:0]           imm,
  input logic [W-1:0]         operand,
  input logic [W-1:0]         result
);
  assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |=> result == '0);

  assert_pass_spare_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 3'd5) |=> result == $past(operand));

  assert_ones_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0 || op_sel == 3'd2 || op_sel == 3'd3)
      |=> $countones(result) == $countones($past(operand)));

  assert_orc_superset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd1) |=> (result & $past(operand)) == $past(operand));

  assert_zero_ctl_ident_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel <= 3'd3 && ctl == '0) |=> result == $past(operand));
endmodule

bind bitperm64 bitperm64_chk #(.W(W)) u_chk (.*);

// File: tb/test_bitperm64.sv
module test_bitperm64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        narrow = 1'b0;
  logic [5:0]  ctl = '0;
  logic [7:0]  imm = '0;
  logic [63:0] operand = '0;
  logic [63:0] result;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitperm64 i_bitperm64 (.clk, .rst_n, .op_sel, .narrow, .ctl, .imm, .operand, .result);

  localparam logic [63:0] RM [6] = '{64'h5555555555555555, 64'h3333333333333333,
    64'h0F0F0F0F0F0F0F0F, 64'h00FF00FF00FF00FF, 64'h0000FFFF0000FFFF, 64'h00000000FFFFFFFF};
  localparam logic [63:0] SL [5] = '{64'h4444444444444444, 64'h3030303030303030,
    64'h0f000f000f000f00, 64'h00ff000000ff0000, 64'h0000ffff00000000};
  localparam logic [63:0] SR [5] = '{64'h2222222222222222, 64'h0c0c0c0c0c0c0c0c,
    64'h00f000f000f000f0, 64'h0000ff000000ff00, 64'h00000000ffff0000};

  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {8'hCC, 64'h0123456789ABCDEF}, {8'hF0, 64'h0000000000000000},
    {8'h96, 64'hFFFFFFFFFFFFFFFF}, {8'h3A, 64'h8000000000000001},
    {8'h5E, 64'hDEADBEEFCAFEF00D}, {8'h17, 64'h00000000FFFFFFFF},
    {8'hE8, 64'hA5A5A5A55A5A5A5A}, {8'h69, 64'h0000000100010001}};

  function automatic logic [63:0] model(input logic [2:0] op, input bit nw,
                                        input logic [5:0] c, input logic [7:0] im,
                                        input logic [63:0] a);
    logic [63:0] x, sw, y;
    logic [5:0] rc;
    logic [4:0] sc;
    x = a;
    rc = nw ? (c & 6'h1F) : c;
    sc = nw ? (c[4:0] & 5'h0F) : c[4:0];
    if (op <= 3'd1 || op == 3'd4) begin
      for (int k = 0; k < 6; k++) if (rc[k]) begin
        sw = ((x & RM[k]) << (1 << k)) | ((x & ~RM[k]) >> (1 << k));
        if (op == 3'd0) x = sw;
        else if (op == 3'd1) x = x | sw;
        else begin
          for (int j = 0; j < 64; j++) begin
            logic [3:0] nb;
            nb = j[k] ? im[7:4] : im[3:0];
            y[j] = nb[{sw[j], x[j]}];
          end
          x = y;
        end
      end
    end else if (op == 3'd2) begin
      for (int k = 4; k >= 0; k--) if (sc[k])
        x = (x & ~(SL[k] | SR[k])) | ((x << (1 << k)) & SL[k]) | ((x >> (1 << k)) & SR[k]);
    end else if (op == 3'd3) begin
      for (int k = 0; k < 5; k++) if (sc[k])
        x = (x & ~(SL[k] | SR[k])) | ((x << (1 << k)) & SL[k]) | ((x >> (1 << k)) & SR[k]);
    end
    return x;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input bit nw, input logic [5:0] c,
                       input logic [7:0] im, input logic [63:0] a);
    op_sel = op; narrow = nw; ctl = c; imm = im; operand = a;
    @(negedge clk);
  endtask

  string rq [8] = '{"R2", "R3", "R4", "R5", "R6", "R9", "R9", "R9"};

  initial begin
    logic [63:0] t;
    repeat (2) @(negedge clk);
    chk("R1 reset", result, 64'h0);
    rst_n = 1'b1;
    apply(3'd0, 1'b0, 6'd63, 8'h00, 64'h1);
    chk("R1 latency", result, 64'h8000000000000000);

    for (int v = 0; v < NV; v++)
      for (int op = 0; op < 8; op++)
        for (int c = 0; c < 64; c++) begin
          apply(3'(op), 1'b0, 6'(c), VEC[v][71:64], VEC[v][63:0]);
          chk(rq[op], result, model(3'(op), 1'b0, 6'(c), VEC[v][71:64], VEC[v][63:0]));
        end

    for (int op = 0; op < 5; op++)
      for (int c = 0; c < 64; c++) begin
        apply(3'(op), 1'b1, 6'(c), 8'h5E, 64'hDEADBEEFCAFEF00D);
        chk("R8 narrow", result, model(3'(op), 1'b1, 6'(c), 8'h5E, 64'hDEADBEEFCAFEF00D));
      end

    apply(3'd1, 1'b0, 6'd63, 8'h00, 64'h1);
    chk("R3 gorc full", result, 64'hFFFFFFFFFFFFFFFF);
    apply(3'd2, 1'b0, 6'd31, 8'h00, 64'h00000000FFFFFFFF);
    chk("R4 zip", result, 64'h5555555555555555);
    apply(3'd2, 1'b0, 6'd63, 8'h00, 64'h00000000FFFFFFFF);
    chk("R4 ctl5 ignored", result, 64'h5555555555555555);
    apply(3'd3, 1'b0, 6'd31, 8'h00, 64'h5555555555555555);
    chk("R5 unzip", result, 64'h00000000FFFFFFFF);
    for (int c = 0; c < 32; c++) begin
      apply(3'd2, 1'b0, 6'(c), 8'h00, 64'h0123456789ABCDEF);
      t = result;
      apply(3'd3, 1'b0, 6'(c), 8'h00, t);
      chk("R5 inverse", result, 64'h0123456789ABCDEF);
    end
    apply(3'd4, 1'b0, 6'd45, 8'hCC, 64'hDEADBEEFCAFEF00D);
    t = result;
    apply(3'd0, 1'b0, 6'd45, 8'h00, 64'hDEADBEEFCAFEF00D);
    chk("R6 CC equals reverse", t, result);
    apply(3'd4, 1'b0, 6'd1, 8'hF0, 64'h0);
    chk("R7 pattern ctl1", result, 64'hAAAAAAAAAAAAAAAA);
    apply(3'd4, 1'b0, 6'd3, 8'hF0, 64'h0);
    chk("R7 pattern ctl3", result, 64'hCCCCCCCCCCCCCCCC);
    apply(3'd0, 1'b1, 6'd63, 8'h00, 64'h1);
    chk("R8 narrow reverse", result, 64'h0000000080000000);
    apply(3'd6, 1'b0, 6'd63, 8'hFF, 64'h123456789ABCDEF0);
    chk("R9 pass", result, 64'h123456789ABCDEF0);
    apply(3'd0, 1'b0, 6'd0, 8'h00, 64'hFEDCBA9876543210);
    chk("R10 identity", result, 64'hFEDCBA9876543210);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset again", result, 64'h0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule